// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that works through a chain of descriptors kept in ordinary memory. Each descriptor occupies eight aligned 32-bit words. Software loads the address of the first descriptor into the head register, sets the run bit and writes the kick register. The channel then reads the descriptor over a word-wide memory port. It copies the requested number of bytes from a source address to a destination address, one word read followed by one word write. It can optionally rewrite the descriptor's first word with its valid bit cleared, and optionally writes a completion word into the descriptor's status slot. It then raises a sticky completion event and moves on to the descriptor named by the link field.

A descriptor whose valid bit is clear parks the channel. The next kick retries the same address, so software can fill in the descriptor and restart the chain. Clearing the run bit lets the current descriptor finish, status write included, and stops the channel before it fetches the next one.

Descriptor word order, by word offset from the 32-byte aligned base:
- 0: command
- 1: count and upper address bits
- 2: source
- 3: unused by this channel
- 4: destination
- 5: unused
- 6: status slot
- 7: link

Command fields:
- bit 31: valid
- bit 8: interrupt enable
- bit 2: clear valid when done
- bits 1:0: status instruction

Count word fields:
- bits 21:0: byte count
- bits 31:28: upper four source address bits
- bits 27:24: upper four destination address bits

Link word: bits 26:0 hold the next descriptor address divided by 32.

Top module: `chain_dma_chan`

## Requirements
- R1: After reset the flags register reads 1 (halted only), the event register and the control register read 0, `irq` is low and `mem_req` is low.
- R2: Software register map, selected by `reg_addr`: 0 control (bit 0 = run), 1 kick (any write), 2 head pointer, 3 scratch word, 4 flags, 5 event, 6 remaining count. Writes to the head register force bits 4:0 to zero.
- R3: A kick while the run bit is set reads the eight descriptor words in order, at addresses head+0 through head+28. These reads carry zero upper address bits.
- R4: The channel copies exactly the byte count, word by word. Sources are {source upper bits, source word} and destinations are {destination upper bits, destination word}, both advancing by 4. On the last write only the lanes holding real bytes are strobed (`mem_be` bit i covers byte address+i). Bytes beyond the count are left untouched. `mem_req` and the access type hold until `mem_ack`.
- R5: When the command word read has bit 31 clear, the channel reads nothing more from that descriptor. It halts (flags bit 0 = 1, bit 1 = 0) and keeps the head address. The next kick refetches that same address.
- R6: With command bit 2 set, after the last data write the command word is written back to descriptor word 0 with bit 31 cleared.
- R7: The status instruction writes to descriptor word 6 after the last data write (and after the word-0 rewrite when present) and before any further fetch. Code 0 writes nothing. Code 1 writes the flags value (2 when no kick is pending). Code 2 writes the command word with bit 31 cleared. Code 3 writes the remaining count, which is 0.
- R8: Event bit 0 is set when each descriptor completes, whatever its interrupt-enable bit. Writing 1 to event bit 0 clears it, but a completion in the same cycle wins. `irq` is high while the event is set and the last completed descriptor had bit 8 set.
- R9: After completion the head register takes the link field times 32, and the channel fetches from there.
- R10: Clearing the run bit during a descriptor lets that descriptor finish, including its status write. The channel then halts without reading the next descriptor, and the head register holds the next address.
- R11: The remaining-count register reads 0 after a completed descriptor. A descriptor with byte count 0 makes no data access.
- R12: Flags bit 2 is set by a kick and cleared when the channel starts. A kick while the run bit is clear stays pending, with no memory access, until the run bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| irq | output | 1 | Completion interrupt (event set and enabled) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 36 | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write lane strobes |
| mem_ack | input | 1 | Access accepted; read data valid this cycle |
| mem_rdata | input | 32 | Read data |

## Verification
Two functions can land in the same cycle: a descriptor completing, which sets the event bit, and a software write that clears that bit. The bench watches its memory model accept the write to the status slot. It then places a clear write exactly in the cycle in which the channel finishes, and expects the event to stay set. A second overlap is a run-bit clear arriving while a descriptor is in flight. It is judged by the completed copy and status write, together with the absence of any read from the following descriptor. The bench acknowledges memory requests after random delays from a fixed seed, so these overlaps meet varying pipeline positions.

// File: rtl/chain_dma_pkg.sv
// Shared constants and types for the linked-descriptor DMA channel.
// Assumes 32-bit memory words and 32-byte aligned descriptors.
package chain_dma_pkg;
    localparam int WORD_BITS = 32;
    localparam int PTR_BITS  = 32;
    localparam int EXT_BITS  = 4;
    localparam int BC_BITS   = 22;
    localparam int LINK_BITS = 27;

    // software register selects
    localparam logic [2:0] RA_CTRL   = 3'd0;
    localparam logic [2:0] RA_KICK   = 3'd1;
    localparam logic [2:0] RA_HEAD   = 3'd2;
    localparam logic [2:0] RA_NOTE   = 3'd3;
    localparam logic [2:0] RA_FLAGS  = 3'd4;
    localparam logic [2:0] RA_EVENT  = 3'd5;
    localparam logic [2:0] RA_REMAIN = 3'd6;

    // command word bit positions
    localparam int C0_VALID = 31;
    localparam int C0_IE    = 8;
    localparam int C0_CLRV  = 2;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_RD, S_WR, S_CLRV, S_STAT, S_DONE
    } seq_state_e;

    // lane strobes for a word holding the last rem bytes
    function automatic logic [3:0] lane_mask(input logic [BC_BITS-1:0] rem);
        logic [3:0] m;
        if (rem >= BC_BITS'(4)) m = 4'hF;
        else begin
            case (rem[1:0])
                2'd1:    m = 4'h1;
                2'd2:    m = 4'h3;
                2'd3:    m = 4'h7;
                default: m = 4'h0;
            endcase
        end
        return m;
    endfunction
endpackage

// File: rtl/chain_dma_regs.sv
// Software-visible registers of the DMA channel: run bit, kick flag,
// head pointer, scratch word, sticky completion event and read mux.
// Assumes the sequencer loads the head pointer only when it completes a
// descriptor; that load takes priority over a software write.
module chain_dma_regs
    import chain_dma_pkg::*;
#(
    parameter int BC_W = BC_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [2:0]           reg_addr,
    input  logic [WORD_BITS-1:0] reg_wdata,
    output logic [WORD_BITS-1:0] reg_rdata,
    input  logic                 halted,
    input  logic                 valid_seen,
    input  logic [BC_W-1:0]      rem_cnt,
    input  logic                 take_kick,
    input  logic                 head_load,
    input  logic [PTR_BITS-1:0]  head_next,
    input  logic                 done_pulse,
    input  logic                 done_ie,
    output logic                 run_en,
    output logic                 kick_pend,
    output logic [PTR_BITS-1:0]  head,
    output logic                 evt_pend,
    output logic                 irq
);
    logic [WORD_BITS-1:0] note_q;
    logic                 ie_q;
    logic                 wr_ctrl, wr_kick, wr_head, wr_note, wr_evt;

    assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
    assign wr_kick = reg_wr && (reg_addr == RA_KICK);
    assign wr_head = reg_wr && (reg_addr == RA_HEAD);
    assign wr_note = reg_wr && (reg_addr == RA_NOTE);
    assign wr_evt  = reg_wr && (reg_addr == RA_EVENT);

    // run bit and scratch word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en <= 1'b0;
            note_q <= '0;
        end else begin
            if (wr_ctrl) run_en <= reg_wdata[0];
            if (wr_note) note_q <= reg_wdata;
        end
    end

    // head pointer: chain advance beats a software write
    always_ff @(posedge clk) begin
        if (!rst_n)         head <= '0;
        else if (head_load) head <= head_next;
        else if (wr_head)   head <= {reg_wdata[PTR_BITS-1:5], 5'b0};
    end

    // kick flag: a new kick beats the sequencer taking the old one
    always_ff @(posedge clk) begin
        if (!rst_n)         kick_pend <= 1'b0;
        else if (wr_kick)   kick_pend <= 1'b1;
        else if (take_kick) kick_pend <= 1'b0;
    end

    // sticky completion event: completion beats a software clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_pend <= 1'b0;
            ie_q     <= 1'b0;
        end else if (done_pulse) begin
            evt_pend <= 1'b1;
            ie_q     <= done_ie;
        end else if (wr_evt && reg_wdata[0]) begin
            evt_pend <= 1'b0;
        end
    end

    assign irq = evt_pend && ie_q;

    // register read mux
    always_comb begin
        case (reg_addr)
            RA_CTRL:   reg_rdata = {31'b0, run_en};
            RA_HEAD:   reg_rdata = head;
            RA_NOTE:   reg_rdata = note_q;
            RA_FLAGS:  reg_rdata = {29'b0, kick_pend, valid_seen, halted};
            RA_EVENT:  reg_rdata = {31'b0, evt_pend};
            RA_REMAIN: reg_rdata = WORD_BITS'(rem_cnt);
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/chain_dma_seq.sv
// Descriptor sequencer: fetches a descriptor, moves its bytes one word
// at a time, performs the optional valid-clear and status writes, and
// follows the link. Assumes source and destination are word aligned and
// that the memory returns read data in the cycle it asserts mem_ack.
module chain_dma_seq
    import chain_dma_pkg::*;
#(
    parameter int EXT_W = EXT_BITS,
    parameter int BC_W  = BC_BITS,
    localparam int AW   = PTR_BITS + EXT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_en,
    input  logic                 kick_pend,
    input  logic [PTR_BITS-1:0]  head,
    output logic                 take_kick,
    output logic                 head_load,
    output logic [PTR_BITS-1:0]  head_next,
    output logic                 done_pulse,
    output logic                 done_ie,
    output logic                 halted,
    output logic                 valid_seen,
    output logic [BC_W-1:0]      rem_cnt,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [AW-1:0]        mem_addr,
    output logic [WORD_BITS-1:0] mem_wdata,
    output logic [3:0]           mem_be,
    input  logic                 mem_ack,
    input  logic [WORD_BITS-1:0] mem_rdata
);
    seq_state_e           state;
    logic [2:0]           widx;
    logic [PTR_BITS-1:0]  base;
    logic [WORD_BITS-1:0] cmd0, src0, dst0, buf_q;
    logic [EXT_W-1:0]     sext, dext;
    logic [BC_W-1:0]      bc0, rem;
    logic [LINK_BITS-1:0] link;
    logic [AW-1:0]        saddr, daddr;
    logic [BC_W-1:0]      step;
    seq_state_e           post_data, post_clrv;
    logic [WORD_BITS-1:0] stat_val;

    assign step      = (rem >= BC_W'(4)) ? BC_W'(4) : rem;
    assign post_clrv = (cmd0[1:0] != 2'd0) ? S_STAT : S_DONE;
    assign post_data = cmd0[C0_CLRV] ? S_CLRV : post_clrv;
    assign head_next = {link, 5'b0};
    assign take_kick = (state == S_IDLE) && kick_pend && run_en;
    assign head_load = (state == S_DONE);
    assign done_pulse = (state == S_DONE);
    assign done_ie   = cmd0[C0_IE];
    assign halted    = (state == S_IDLE);
    assign rem_cnt   = rem;

    // status word selected by the instruction code
    always_comb begin
        case (cmd0[1:0])
            2'd1:    stat_val = {29'b0, kick_pend, 1'b1, 1'b0};
            2'd2:    stat_val = cmd0 & ~(WORD_BITS'(1) << C0_VALID);
            2'd3:    stat_val = WORD_BITS'(rem);
            default: stat_val = '0;
        endcase
    end

    // sequencer state, descriptor capture and transfer counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            widx <= '0; base <= '0; cmd0 <= '0; src0 <= '0; dst0 <= '0;
            buf_q <= '0; sext <= '0; dext <= '0; bc0 <= '0; rem <= '0;
            link <= '0; saddr <= '0; daddr <= '0; valid_seen <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (take_kick) begin
                    base  <= head;
                    widx  <= '0;
                    state <= S_FETCH;
                end
                S_FETCH: if (mem_ack) begin
                    case (widx)
                        3'd0: cmd0 <= mem_rdata;
                        3'd1: begin
                            sext <= mem_rdata[31 -: EXT_W];
                            dext <= mem_rdata[27 -: EXT_W];
                            bc0  <= mem_rdata[BC_W-1:0];
                        end
                        3'd2: src0 <= mem_rdata;
                        3'd4: dst0 <= mem_rdata;
                        3'd7: link <= mem_rdata[LINK_BITS-1:0];
                        default: ;
                    endcase
                    if (widx == 3'd0 && !mem_rdata[C0_VALID]) begin
                        valid_seen <= 1'b0;
                        state      <= S_IDLE;
                    end else begin
                        if (widx == 3'd0) valid_seen <= 1'b1;
                        widx <= widx + 3'd1;
                        if (widx == 3'd7) begin
                            saddr <= {sext, src0};
                            daddr <= {dext, dst0};
                            rem   <= bc0;
                            state <= (bc0 == '0) ? post_data : S_RD;
                        end
                    end
                end
                S_RD: if (mem_ack) begin
                    buf_q <= mem_rdata;
                    state <= S_WR;
                end
                S_WR: if (mem_ack) begin
                    rem   <= rem - step;
                    saddr <= saddr + AW'(4);
                    daddr <= daddr + AW'(4);
                    state <= (rem <= BC_W'(4)) ? post_data : S_RD;
                end
                S_CLRV: if (mem_ack) state <= post_clrv;
                S_STAT: if (mem_ack) state <= S_DONE;
                S_DONE: begin
                    base  <= head_next;
                    widx  <= '0;
                    state <= run_en ? S_FETCH : S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // memory request decode per state
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_be    = 4'hF;
        case (state)
            S_FETCH: mem_addr = AW'({base[PTR_BITS-1:5], widx, 2'b00});
            S_RD:    mem_addr = saddr;
            S_WR: begin
                mem_we = 1'b1; mem_addr = daddr; mem_wdata = buf_q;
                mem_be = lane_mask(rem);
            end
            S_CLRV: begin
                mem_we = 1'b1; mem_addr = AW'(base);
                mem_wdata = cmd0 & ~(WORD_BITS'(1) << C0_VALID);
            end
            S_STAT: begin
                mem_we = 1'b1; mem_addr = AW'({base[PTR_BITS-1:5], 5'd24});
                mem_wdata = stat_val;
            end
            default: mem_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/chain_dma_chan.sv
// Top of the linked-descriptor DMA channel: register block plus
// descriptor sequencer. Assumes a single memory port with one access
// outstanding at a time.
module chain_dma_chan
    import chain_dma_pkg::*;
#(
    parameter int EXT_W = EXT_BITS,
    parameter int BC_W  = BC_BITS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic [2:0]                    reg_addr,
    input  logic [WORD_BITS-1:0]          reg_wdata,
    output logic [WORD_BITS-1:0]          reg_rdata,
    output logic                          irq,
    output logic                          mem_req,
    output logic                          mem_we,
    output logic [PTR_BITS+EXT_W-1:0]     mem_addr,
    output logic [WORD_BITS-1:0]          mem_wdata,
    output logic [3:0]                    mem_be,
    input  logic                          mem_ack,
    input  logic [WORD_BITS-1:0]          mem_rdata
);
    logic                run_en, kick_pend, evt_pend;
    logic                take_kick, head_load, done_pulse, done_ie;
    logic                halted, valid_seen;
    logic [PTR_BITS-1:0] head, head_next;
    logic [BC_W-1:0]     rem_cnt;

    chain_dma_regs #(.BC_W(BC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .halted(halted),
        .valid_seen(valid_seen), .rem_cnt(rem_cnt), .take_kick(take_kick),
        .head_load(head_load), .head_next(head_next), .done_pulse(done_pulse),
        .done_ie(done_ie), .run_en(run_en), .kick_pend(kick_pend), .head(head),
        .evt_pend(evt_pend), .irq(irq)
    );

    chain_dma_seq #(.EXT_W(EXT_W), .BC_W(BC_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .kick_pend(kick_pend),
        .head(head), .take_kick(take_kick), .head_load(head_load),
        .head_next(head_next), .done_pulse(done_pulse), .done_ie(done_ie),
        .halted(halted), .valid_seen(valid_seen), .rem_cnt(rem_cnt),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );
endmodule

// File: rtl/chain_dma_chk.sv
// Property checker for the DMA channel, bound to the top module.
// Assumes synchronous active-low reset; all properties hold from reset.
module chain_dma_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       evt_clr,
    input logic       mem_req,
    input logic       mem_we,
    input logic       mem_ack,
    input logic [3:0] mem_be,
    input logic       evt_pend,
    input logic       done_pulse,
    input logic       halted,
    input logic       kick_pend
);
    // an unacknowledged request keeps its type and lanes (R4)
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_be));

    // every write strobes at least one lane (R4)
    p_wr_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_be != 4'b0);

    // a pending event persists unless software clears it (R8)
    p_evt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pend && !evt_clr |=> evt_pend);

    // a completion always leaves the event set, even against a clear (R8)
    p_done_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> evt_pend);

    // a parked channel without a pending kick stays off the memory (R12)
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        halted && !kick_pend |=> !mem_req);
endmodule

bind chain_dma_chan chain_dma_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .evt_clr(reg_wr && (reg_addr == 3'd5) && reg_wdata[0]),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_be(mem_be),
    .evt_pend(evt_pend), .done_pulse(done_pulse), .halted(halted),
    .kick_pend(kick_pend)
);

// File: tb/chain_dma_chan_bench.sv
module chain_dma_chan_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        mem_req, mem_we;
    logic [35:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = 32'd0;

    int n_chk = 0, n_fail = 0;
    bit done_flag = 0;

    logic [31:0] mem [0:1023];
    logic [35:0] rlog [0:255];
    logic [35:0] wlog [0:255];
    logic [31:0] wdat [0:255];
    int rlog_n = 0, wlog_n = 0;
    event stat_ev;

    chain_dma_chan u_chain_dma_chan (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    always #5 clk = ~clk;

    // memory model: random acknowledge delay, logs every accepted access
    initial begin
        forever begin
            @(negedge clk);
            mem_ack = mem_req && ($urandom_range(0, 3) != 0);
            if (mem_ack) begin
                if (mem_we) begin
                    for (int i = 0; i < 4; i++)
                        if (mem_be[i]) mem[mem_addr[11:2]][8*i +: 8] = mem_wdata[8*i +: 8];
                    if (wlog_n < 256) begin
                        wlog[wlog_n] = mem_addr; wdat[wlog_n] = mem_wdata; wlog_n++;
                    end
                    if (mem_addr[4:0] == 5'd24) -> stat_ev;
                end else begin
                    mem_rdata = mem[mem_addr[11:2]];
                    if (rlog_n < 256) begin rlog[rlog_n] = mem_addr; rlog_n++; end
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic wait_halt();
        logic [31:0] f;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 5000; i++) begin
            reg_read(3'd4, f);
            if (f[0]) break;
        end
    endtask

    task automatic clear_logs();
        rlog_n = 0; wlog_n = 0;
    endtask

    task automatic put_desc(input int at, input logic [31:0] c0, input logic [31:0] c1,
                            input logic [31:0] s, input logic [31:0] d, input int nxt);
        mem[at/4 + 0] = c0; mem[at/4 + 1] = c1; mem[at/4 + 2] = s; mem[at/4 + 3] = 32'd0;
        mem[at/4 + 4] = d;  mem[at/4 + 5] = 32'd0; mem[at/4 + 6] = 32'd0;
        mem[at/4 + 7] = 32'(nxt) >> 5;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v, c0, c1;
        logic [31:0] srcw [0:15];
        int bc, nw, st;
        bit clrv, ie, ok;
        logic [3:0] sx, dx;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 1024; i++) mem[i] = 32'd0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        reg_read(3'd4, v); check(v == 32'd1, "R1 flags", 36'(v), 36'd1);
        reg_read(3'd5, v); check(v == 32'd0, "R1 event", 36'(v), 36'd0);
        reg_read(3'd0, v); check(v == 32'd0, "R1 ctrl", 36'(v), 36'd0);
        check(!irq && !mem_req, "R1 irq/mem_req", {34'd0, irq, mem_req}, 36'd0);

        // R2: head alignment and scratch word
        reg_write(3'd2, 32'h0000_0A3F);
        reg_read(3'd2, v); check(v == 32'h0000_0A20, "R2 head align", 36'(v), 36'h0A20);
        reg_write(3'd3, 32'hDEAD_BEEF);
        reg_read(3'd3, v); check(v == 32'hDEAD_BEEF, "R2 scratch", 36'(v), 36'hDEADBEEF);

        // R3/R4/R6/R7/R8/R9/R11: single descriptors, parked by an invalid link
        reg_write(3'd0, 32'd1);
        for (int it = 0; it < 8; it++) begin
            bc = (it == 0) ? 0 : (it == 1) ? 4 : $urandom_range(1, 40);
            nw = (bc + 3) / 4;
            st = it % 4;
            clrv = 1'($urandom_range(0, 1));
            ie = 1'($urandom_range(0, 1));
            sx = 4'($urandom_range(0, 15));
            dx = 4'($urandom_range(0, 15));
            c0 = 32'h8000_0000 | ($urandom & 32'h3FFF_FEF0) | (32'(ie) << 8) | (32'(clrv) << 2) | 32'(st);
            c1 = {sx, dx, 2'b00, 22'(bc)};
            put_desc(32'h40, c0, c1, 32'h400, 32'h800, 32'hC0);
            mem[32'hC0/4] = 32'd0;
            for (int k = 0; k < 16; k++) begin
                srcw[k] = $urandom; mem[256 + k] = srcw[k]; mem[512 + k] = 32'hA5A5_A5A5;
            end
            clear_logs();
            reg_write(3'd2, 32'h40);
            reg_write(3'd1, 32'd0);
            wait_halt();

            ok = 1;
            for (int j = 0; j < 8; j++) if (rlog[j] != 36'(32'h40 + 4*j)) ok = 0;
            check(ok, "R3 fetch order", rlog[0], 36'h40);
            if (bc > 0) check(rlog[8] == {sx, 32'h400}, "R4 source address", rlog[8], {sx, 32'h400});
            check(rlog_n == 9 + nw, "R11 read count", 36'(rlog_n), 36'(9 + nw));
            ok = 1;
            for (int k = 0; k < nw*4 + 4; k++)
                if (mem[512 + k/4][8*(k%4) +: 8] != ((k < bc) ? srcw[k/4][8*(k%4) +: 8] : 8'hA5)) ok = 0;
            check(ok, "R4 copied bytes", 36'(bc), 36'(bc));
            ok = 1;
            for (int k = 0; k < nw; k++) if (wlog[k] != {dx, 32'h800 + 32'(4*k)}) ok = 0;
            check(ok, "R4 dest addresses", wlog[0], {dx, 32'h800});
            check(wlog_n == nw + int'(clrv) + int'(st != 0), "R7 write count",
                  36'(wlog_n), 36'(nw + int'(clrv) + int'(st != 0)));
            if (clrv) check(wlog[nw] == 36'h40 && wdat[nw] == (c0 & 32'h7FFF_FFFF),
                            "R6 valid cleared", 36'(wdat[nw]), 36'(c0 & 32'h7FFF_FFFF));
            if (st != 0) begin
                v = (st == 1) ? 32'd2 : (st == 2) ? (c0 & 32'h7FFF_FFFF) : 32'd0;
                check(wlog[wlog_n-1] == 36'h58 && wdat[wlog_n-1] == v, "R7 status word",
                      36'(wdat[wlog_n-1]), 36'(v));
            end
            check(rlog[rlog_n-1] == 36'hC0, "R9 link followed", rlog[rlog_n-1], 36'hC0);
            reg_read(3'd2, v); check(v == 32'hC0, "R9 head", 36'(v), 36'hC0);
            reg_read(3'd4, v); check(v == 32'd1, "R5 parked flags", 36'(v), 36'd1);
            reg_read(3'd6, v); check(v == 32'd0, "R11 remain", 36'(v), 36'd0);
            reg_read(3'd5, v); check(v == 32'd1, "R8 event set", 36'(v), 36'd1);
            check(irq == ie, "R8 irq follows enable", 36'(irq), 36'(ie));
            reg_write(3'd5, 32'd1);
            reg_read(3'd5, v); check(v == 32'd0 && !irq, "R8 event clear", 36'(v), 36'd0);
        end

        // R5: kick refetches the same parked address
        put_desc(32'hC0, 32'h8000_0000, 32'd8, 32'h400, 32'h800, 32'h100);
        mem[32'h100/4] = 32'd0;
        clear_logs();
        reg_write(3'd1, 32'd0);
        wait_halt();
        check(rlog[0] == 36'hC0, "R5 refetch address", rlog[0], 36'hC0);
        reg_read(3'd2, v); check(v == 32'h100, "R5 chain resumed", 36'(v), 36'h100);
        mem[32'hC0/4] = 32'd0;

        // R10: run bit cleared mid-descriptor
        put_desc(32'h140, 32'h8000_0003, 32'd40, 32'h400, 32'h800, 32'h180);
        put_desc(32'h180, 32'h8000_0000, 32'd4, 32'h400, 32'h800, 32'hC0);
        for (int k = 0; k < 16; k++) mem[512 + k] = 32'hA5A5_A5A5;
        clear_logs();
        reg_write(3'd2, 32'h140);
        reg_write(3'd1, 32'd0);
        repeat (6) @(negedge clk);
        reg_write(3'd0, 32'd0);
        wait_halt();
        ok = 1;
        for (int j = 0; j < rlog_n; j++) if (rlog[j] >= 36'h180 && rlog[j] < 36'h1A0) ok = 0;
        check(ok, "R10 next not fetched", 36'(rlog_n), 36'd0);
        check(wlog_n == 11 && wlog[10] == 36'h158, "R10 status written", 36'(wlog_n), 36'd11);
        reg_read(3'd2, v); check(v == 32'h180, "R10 head", 36'(v), 36'h180);
        reg_write(3'd5, 32'd1);

        // R12: kick while stopped stays pending
        clear_logs();
        reg_write(3'd1, 32'd0);
        repeat (10) @(negedge clk);
        reg_read(3'd4, v); check(v[2] && v[0], "R12 kick pending", 36'(v), 36'd5);
        check(rlog_n == 0, "R12 no access", 36'(rlog_n), 36'd0);
        reg_write(3'd0, 32'd1);
        wait_halt();
        reg_read(3'd4, v); check(v[2] == 1'b0, "R12 kick taken", 36'(v), 36'd1);
        check(rlog_n > 0 && rlog[0] == 36'h180, "R12 started", rlog[0], 36'h180);
        reg_read(3'd2, v); check(v == 32'hC0, "R12 chain head", 36'(v), 36'hC0);
        reg_write(3'd5, 32'd1);

        // R8: completion and software clear in the same cycle
        put_desc(32'h1C0, 32'h8000_0103, 32'd8, 32'h400, 32'h800, 32'hC0);
        reg_write(3'd2, 32'h1C0);
        reg_write(3'd1, 32'd0);
        @(stat_ev);
        @(negedge clk); reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 32'd1;
        @(negedge clk); reg_wr = 1'b0;
        wait_halt();
        reg_read(3'd5, v); check(v == 32'd1, "R8 set wins over clear", 36'(v), 36'd1);
        check(irq == 1'b1, "R8 irq with enable", 36'(irq), 36'd1);
        check(mem[32'h1D8/4] == 32'd0, "R7 remaining count status", 36'(mem[32'h1D8/4]), 36'd0);

        finish_run();
    end
endmodule